// File: doc/BRIEF.md
# TDM Stream Capture Analyzer

This block is a diagnostic capture engine for a backplane that carries several framers' serial TDM streams. Each of eight framer ports offers four serial streams. The block watches one stream on one port and stores its bytes in a 32-byte capture memory. Software can read that memory through a simple address/data read port.

There are two capture modes:

- **Frame mode** stores every channel of one frame in order.
- **Channel mode** stores one chosen channel once per frame, for 32 frames in a row.

Capture either keeps going, overwriting the memory in a ring, or stops after 32 bytes (single-shot). When a single-shot capture ends and the interrupt enable is set, a sticky interrupt flag is raised. A one-cycle arm pulse starts or restarts a capture.

If the port, stream, mode or channel selection changes while a capture is pending or running, that capture is dropped. It starts again from the next frame pulse of the new source.

Top module: `tdm_capture_analyzer`

## Requirements
- R1: After reset `irq_o` is 0, every memory byte reads 0, and no byte is written until `arm_i` is pulsed. `rd_data_o` is the byte at `rd_addr_i` with no clock delay.
- R2: A serial bit is taken only on a clock where `bit_en_i` of the selected port is 1. A bit taken while that port's `fp_ni` is 0 is the MSB of channel 0. Each channel is 8 bits sent MSB first, and there are 32 channels per frame.
- R3: The captured bit is `ser_i[port_sel_i*4 + strm_sel_i]`. The stream codes are 0 = system data in, 1 = system data out, 2 = control in and 3 = control out. Frame pulse and bit enable come from the same selected port.
- R4: In frame mode (`chan_mode_i` = 0), capture starts at the first frame pulse after arming. Memory address k receives channel k of that frame.
- R5: In channel mode (`chan_mode_i` = 1), address k receives channel `chan_sel_i` of the k-th frame counted from the first frame pulse after arming.
- R6: With `single_i` = 0, the write address wraps from 31 to 0 and capture goes on without stopping.
- R7: With `single_i` = 1, capture stops after the byte at address 31 is stored. The memory is then left untouched until the next arm pulse.
- R8: A completed single-shot capture sets the sticky `irq_o`, but only when `irq_en_i` is 1. A pulse on `irq_clr_i` clears it, and a new set in the same cycle wins over the clear.
- R9: An `arm_i` pulse at any time resets the write address to 0 and waits for the next frame pulse.
- R10: A change of port, stream, mode or channel selection while armed aborts the capture. The write address returns to 0 and capture restarts at the next frame pulse of the new source. The same change while stopped has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ser_i | input | 32 | Serial data, four streams per port, index port*4+stream |
| bit_en_i | input | 8 | Per-port bit strobe, one clock per serial bit |
| fp_ni | input | 8 | Per-port frame pulse, active low, marks channel 0 MSB |
| port_sel_i | input | 3 | Framer port to watch |
| strm_sel_i | input | 2 | Stream type to watch |
| chan_mode_i | input | 1 | 0 frame capture, 1 single-channel capture |
| chan_sel_i | input | 5 | Channel captured in channel mode |
| single_i | input | 1 | 1 single-shot, 0 continuous |
| irq_en_i | input | 1 | Interrupt enable |
| arm_i | input | 1 | Start/restart pulse |
| irq_clr_i | input | 1 | Interrupt clear pulse |
| rd_addr_i | input | 5 | Capture memory read address |
| rd_data_o | output | 8 | Capture memory read data |
| irq_o | output | 1 | Sticky single-shot completion flag |

## Verification
The bench gives every port its own frame pulse phase and random data on all 32 streams. A wrong port or stream index therefore fills memory with bytes that differ from the model's, and a frame pulse taken from the wrong port shifts every byte's alignment.

Channel mode runs for a full 32 frames, which catches an off-by-one channel compare or a pointer that advances on every byte instead of only the selected one. The bench pulses arm and changes the selection in the middle of a capture. A design that keeps its old pointer, or restarts before the next frame pulse, then writes bytes to the wrong addresses.

Memory is swept on every clock after a single-shot completion and after a selection change while stopped. This exposes late writes, an interrupt raised with the enable clear, and a clear that beats a same-cycle set.

// File: rtl/tdm_cap_pkg.sv
package tdm_cap_pkg;
  typedef enum logic [1:0] {
    CAP_IDLE = 2'd0,
    CAP_WAIT = 2'd1,
    CAP_RUN  = 2'd2
  } cap_state_e;
endpackage

// File: rtl/tdm_src_mux.sv
module tdm_src_mux #(
  parameter int NPORT = 8,
  parameter int NSTRM = 4,
  localparam int PW = $clog2(NPORT),
  localparam int SW = $clog2(NSTRM)
) (
  input  logic [NPORT*NSTRM-1:0] ser_i,
  input  logic [NPORT-1:0]       bit_en_i,
  input  logic [NPORT-1:0]       fp_ni,
  input  logic [PW-1:0]          port_sel_i,
  input  logic [SW-1:0]          strm_sel_i,
  output logic                   bit_o,
  output logic                   bit_en_o,
  output logic                   fp_o
);
  logic [NSTRM-1:0] port_bus [NPORT];

  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign port_bus[p] = ser_i[p*NSTRM +: NSTRM];
  end

  assign bit_o    = port_bus[port_sel_i][strm_sel_i];
  assign bit_en_o = bit_en_i[port_sel_i];
  assign fp_o     = ~fp_ni[port_sel_i];
endmodule

// File: rtl/tdm_deser.sv
module tdm_deser #(
  parameter int DW = 8,
  parameter int CH_PER_FRM = 32,
  localparam int BW = $clog2(DW),
  localparam int CHW = $clog2(CH_PER_FRM),
  localparam int POSW = BW + CHW
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           bit_i,
  input  logic           bit_en_i,
  input  logic           fp_i,
  output logic           byte_vld_o,
  output logic [DW-1:0]  byte_o,
  output logic [CHW-1:0] chan_o
);
  logic [POSW-1:0] pos_q, pos_d;
  logic [DW-2:0]   sh_q;

  // frame pulse pins bit position to zero
  assign pos_d      = fp_i ? '0 : pos_q + 1'b1;
  assign byte_vld_o = bit_en_i && (pos_d[BW-1:0] == {BW{1'b1}});
  assign byte_o     = {sh_q, bit_i};
  assign chan_o     = pos_d[POSW-1:BW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q <= '0;
      sh_q  <= '0;
    end else if (bit_en_i) begin
      pos_q <= pos_d;
      sh_q  <= {sh_q[DW-3:0], bit_i};
    end
  end

  // R2
  byte_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_vld_o |-> !fp_i);
endmodule

// File: rtl/tdm_cap_mem.sv
module tdm_cap_mem #(
  parameter int DEPTH = 32,
  parameter int DW = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] waddr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ent [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic [DW-1:0] q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q <= '0;
      else if (we_i && waddr_i == AW'(i)) q <= wdata_i;
    end
    assign ent[i] = q;
  end

  assign rdata_o = ent[raddr_i];
endmodule

// File: rtl/tdm_cap_ctrl.sv
module tdm_cap_ctrl import tdm_cap_pkg::*; #(
  parameter int DEPTH = 32,
  parameter int CH_PER_FRM = 32,
  parameter int DW = 8,
  parameter int SELW = 11,
  localparam int AW = $clog2(DEPTH),
  localparam int CHW = $clog2(CH_PER_FRM)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [SELW-1:0] sel_i,
  input  logic            chan_mode_i,
  input  logic [CHW-1:0]  chan_sel_i,
  input  logic            single_i,
  input  logic            irq_en_i,
  input  logic            arm_i,
  input  logic            irq_clr_i,
  input  logic            bit_en_i,
  input  logic            fp_i,
  input  logic            byte_vld_i,
  input  logic [CHW-1:0]  chan_i,
  input  logic [DW-1:0]   byte_i,
  output logic            we_o,
  output logic [AW-1:0]   waddr_o,
  output logic [DW-1:0]   wdata_o,
  output logic            irq_o
);
  cap_state_e      st_q, st_d;
  logic [AW-1:0]   ptr_q, ptr_d;
  logic [SELW-1:0] sel_q;
  logic            irq_q, irq_d;
  logic            chg, abort, hit, last, done;

  assign chg   = sel_i != sel_q;
  assign abort = chg && (st_q != CAP_IDLE);
  assign hit   = byte_vld_i && (!chan_mode_i || chan_i == chan_sel_i);
  assign we_o  = !arm_i && !abort && (st_q == CAP_RUN) && hit;
  assign last  = ptr_q == AW'(DEPTH-1);
  assign done  = we_o && last && single_i;

  always_comb begin
    st_d  = st_q;
    ptr_d = ptr_q;
    if (arm_i || abort) begin
      st_d  = CAP_WAIT;
      ptr_d = '0;
    end else if (st_q == CAP_WAIT && bit_en_i && fp_i) begin
      st_d = CAP_RUN;
    end else if (we_o) begin
      ptr_d = last ? '0 : ptr_q + 1'b1;
      if (done) st_d = CAP_IDLE;
    end
  end

  // set beats clear
  always_comb begin
    irq_d = irq_q;
    if (done && irq_en_i) irq_d = 1'b1;
    else if (irq_clr_i)   irq_d = 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= CAP_IDLE;
      ptr_q <= '0;
      sel_q <= '0;
      irq_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      ptr_q <= ptr_d;
      sel_q <= sel_i;
      irq_q <= irq_d;
    end
  end

  assign waddr_o = ptr_q;
  assign wdata_o = byte_i;
  assign irq_o   = irq_q;

  // R9
  arm_restart_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arm_i |=> (st_q == CAP_WAIT) && (ptr_q == '0));
  // R10
  sel_abort_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != CAP_IDLE && chg) |=> (st_q == CAP_WAIT) && (ptr_q == '0));
  // R7
  idle_no_wr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == CAP_IDLE) |-> !we_o);
  // R8
  irq_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(irq_q) |-> $past(irq_en_i && single_i));
  // R8
  irq_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_q && !irq_clr_i) |=> irq_q);
endmodule

// File: rtl/tdm_capture_analyzer.sv
module tdm_capture_analyzer #(
  parameter int NPORT = 8,
  parameter int NSTRM = 4,
  parameter int CH_PER_FRM = 32,
  parameter int DW = 8,
  parameter int DEPTH = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NPORT*NSTRM-1:0]     ser_i,
  input  logic [NPORT-1:0]           bit_en_i,
  input  logic [NPORT-1:0]           fp_ni,
  input  logic [$clog2(NPORT)-1:0]   port_sel_i,
  input  logic [$clog2(NSTRM)-1:0]   strm_sel_i,
  input  logic                       chan_mode_i,
  input  logic [$clog2(CH_PER_FRM)-1:0] chan_sel_i,
  input  logic                       single_i,
  input  logic                       irq_en_i,
  input  logic                       arm_i,
  input  logic                       irq_clr_i,
  input  logic [$clog2(DEPTH)-1:0]   rd_addr_i,
  output logic [DW-1:0]              rd_data_o,
  output logic                       irq_o
);
  localparam int PW   = $clog2(NPORT);
  localparam int SW   = $clog2(NSTRM);
  localparam int CHW  = $clog2(CH_PER_FRM);
  localparam int AW   = $clog2(DEPTH);
  localparam int SELW = PW + SW + 1 + CHW;

  logic           s_bit, s_en, s_fp;
  logic           b_vld;
  logic [DW-1:0]  b_data;
  logic [CHW-1:0] b_chan;
  logic           we;
  logic [AW-1:0]  waddr;
  logic [DW-1:0]  wdata;
  logic [SELW-1:0] sel_vec;

  assign sel_vec = {port_sel_i, strm_sel_i, chan_mode_i, chan_sel_i};

  tdm_src_mux #(.NPORT(NPORT), .NSTRM(NSTRM)) u_mux (
    .ser_i      (ser_i),
    .bit_en_i   (bit_en_i),
    .fp_ni      (fp_ni),
    .port_sel_i (port_sel_i),
    .strm_sel_i (strm_sel_i),
    .bit_o      (s_bit),
    .bit_en_o   (s_en),
    .fp_o       (s_fp)
  );

  tdm_deser #(.DW(DW), .CH_PER_FRM(CH_PER_FRM)) u_deser (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .bit_i      (s_bit),
    .bit_en_i   (s_en),
    .fp_i       (s_fp),
    .byte_vld_o (b_vld),
    .byte_o     (b_data),
    .chan_o     (b_chan)
  );

  tdm_cap_ctrl #(.DEPTH(DEPTH), .CH_PER_FRM(CH_PER_FRM), .DW(DW), .SELW(SELW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .sel_i       (sel_vec),
    .chan_mode_i (chan_mode_i),
    .chan_sel_i  (chan_sel_i),
    .single_i    (single_i),
    .irq_en_i    (irq_en_i),
    .arm_i       (arm_i),
    .irq_clr_i   (irq_clr_i),
    .bit_en_i    (s_en),
    .fp_i        (s_fp),
    .byte_vld_i  (b_vld),
    .chan_i      (b_chan),
    .byte_i      (b_data),
    .we_o        (we),
    .waddr_o     (waddr),
    .wdata_o     (wdata),
    .irq_o       (irq_o)
  );

  tdm_cap_mem #(.DEPTH(DEPTH), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (we),
    .waddr_i (waddr),
    .wdata_i (wdata),
    .raddr_i (rd_addr_i),
    .rdata_o (rd_data_o)
  );
endmodule

// File: tb/tdm_capture_analyzer_tb_top.sv
`timescale 1ns/1ps
module tdm_capture_analyzer_tb_top;
  localparam int NP = 8;
  localparam int NS = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ser = '0;
  logic [7:0]  bit_en = '0;
  logic [7:0]  fp_n = '1;
  logic [2:0]  port_sel = '0;
  logic [1:0]  strm_sel = '0;
  logic        chan_mode = 1'b0;
  logic [4:0]  chan_sel = '0;
  logic        single = 1'b0;
  logic        irq_en = 1'b0;
  logic        arm = 1'b0;
  logic        irq_clr = 1'b0;
  logic [4:0]  rd_addr = '0;
  logic [7:0]  rd_data;
  logic        irq;

  always #10 clk = ~clk;

  tdm_capture_analyzer dut_i (
    .clk_i(clk), .rst_ni(rst_n), .ser_i(ser), .bit_en_i(bit_en), .fp_ni(fp_n),
    .port_sel_i(port_sel), .strm_sel_i(strm_sel), .chan_mode_i(chan_mode),
    .chan_sel_i(chan_sel), .single_i(single), .irq_en_i(irq_en), .arm_i(arm),
    .irq_clr_i(irq_clr), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .irq_o(irq)
  );

  int    vecs = 0;
  int    fails = 0;
  int    cyc = 0;
  int    bidx = 255;
  string cur_req = "R1";

  // behavioural reference model
  logic [7:0] m_mem [32];
  int m_st, m_ptr, m_cnt, m_sh, m_prev;
  bit m_irq;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_ptr = 0; m_cnt = 0; m_sh = 0; m_prev = 0; m_irq = 0;
      foreach (m_mem[i]) m_mem[i] = 8'h00;
    end else begin
      int  cur, ncnt, byt, ch, d;
      bit  be, fpl, bv, chg, wr, done;
      be  = bit_en[port_sel];
      fpl = !fp_n[port_sel];
      d   = ser[port_sel*NS + strm_sel];
      cur = {port_sel, strm_sel, chan_mode, chan_sel};
      chg = (cur != m_prev);
      m_prev = cur;
      bv = 0; ch = 0; byt = 0;
      if (be) begin
        ncnt = fpl ? 0 : (m_cnt + 1) % 256;
        byt  = ((m_sh << 1) | d) & 255;
        bv   = (ncnt % 8) == 7;
        ch   = ncnt / 8;
        m_cnt = ncnt;
        m_sh  = fpl ? d : byt;
      end
      wr = 0; done = 0;
      if (arm || (m_st != 0 && chg)) begin
        m_st = 1; m_ptr = 0;
      end else if (m_st == 1 && be && fpl) begin
        m_st = 2;
      end else if (m_st == 2 && bv && (!chan_mode || ch == chan_sel)) begin
        wr = 1;
        m_mem[m_ptr] = byt[7:0];
        if (m_ptr == 31) begin
          m_ptr = 0;
          if (single) begin done = 1; m_st = 0; end
        end else m_ptr++;
      end
      if (done && irq_en) m_irq = 1;
      else if (irq_clr) m_irq = 0;
    end
  end

  task automatic check(string what, int got, int exp);
    vecs++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0h exp %0h (cycle %0d)", cur_req, what, got, exp, cyc);
    end
  endtask

  // one clock: drive at negedge, compare after posedge
  task automatic step();
    @(negedge clk);
    cyc++;
    rd_addr = 5'(cyc % 32);
    if (cyc % 2 == 0) begin
      bidx = (bidx + 1) % 256;
      bit_en = '1;
      ser = $urandom;
      for (int p = 0; p < NP; p++) fp_n[p] = !(((bidx + p*8) % 256) == 0);
    end else begin
      bit_en = '0;
      fp_n = '1;
    end
    @(posedge clk);
    #5;
    check("rd_data", rd_data, m_mem[rd_addr]);
    check("irq", irq, m_irq);
  endtask

  task automatic run(int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic pulse_arm();
    arm = 1'b1; step(); arm = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end

  initial begin
    // R1: reset state and nothing stored before arming
    cur_req = "R1";
    run(4);
    rst_n = 1'b1;
    port_sel = 3; strm_sel = 1; single = 1; irq_en = 1;
    run(700);

    // R4 R2 R3: frame mode single shot with interrupt
    cur_req = "R4";
    pulse_arm();
    run(1300);
    // R8: set seen above, now clear
    cur_req = "R8";
    irq_clr = 1'b1; step(); irq_clr = 1'b0;
    run(20);
    // R7: no writes after single shot; R10 change while stopped ignored
    cur_req = "R7";
    run(600);
    cur_req = "R10";
    port_sel = 6;
    run(600);

    // R5: channel mode, interrupt disabled
    cur_req = "R5";
    chan_mode = 1; chan_sel = 17; port_sel = 5; strm_sel = 2; irq_en = 0;
    run(3);
    pulse_arm();
    run(17000);

    // R6: continuous frame mode ring overwrite
    cur_req = "R6";
    chan_mode = 0; single = 0; port_sel = 0; strm_sel = 3;
    pulse_arm();
    run(2200);

    // R10: selection change mid capture
    cur_req = "R10";
    strm_sel = 0;
    run(900);
    chan_mode = 1; chan_sel = 31;
    run(1500);

    // R9: re-arm mid capture
    cur_req = "R9";
    run(37);
    pulse_arm();
    run(1200);

    // R3: last port, system data in, single shot with interrupt
    cur_req = "R3";
    chan_mode = 0; port_sel = 7; strm_sel = 0; single = 1; irq_en = 1;
    pulse_arm();
    run(1400);

    // R8: clear in same cycle as set - set wins
    cur_req = "R8";
    chan_mode = 0; port_sel = 2; strm_sel = 2;
    pulse_arm();
    irq_clr = 1'b1;
    run(1300);
    irq_clr = 1'b0;
    run(10);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, fails);
    $finish;
  end
endmodule